// File: doc/BRIEF.md
# Planar Pixel Row Writeback Engine

This block takes one cached row of eight pixels and writes it back to a bit-plane organised bitmap in byte-wide memory. Each pixel carries up to eight bits, and a per-pixel pending mask marks which of the eight pixels hold new data. For each active bit plane the engine gathers bit n of all eight pixels into one byte, placing pixel x at bit x. It writes that byte to the plane's slot inside the tile. When only some pixels are pending, it first reads the stored byte and keeps the bits of the pixels that are not pending.

A plotting front end presents the row, mask, base address, bits-per-pixel code and speed select, then pulses `start`. The engine latches all of these and runs the planes in ascending order. It drives a single-port byte memory whose strobes are held for the full access cost, pulses `done` after the last write, and clears its copy of the pending mask. The state machine has five states. IDLE waits for a start. PREP picks the access for the current plane. READ and WRITE are the timed memory accesses. DONE is the completion cycle. The transitions are:

- start: IDLE to PREP.
- no pending pixels: PREP to DONE.
- full mask: PREP to WRITE.
- partial mask: PREP to READ.
- read complete: READ to WRITE.
- plane complete: WRITE to PREP.
- last plane complete: WRITE to DONE.
- retire: DONE to IDLE.

Top module: `pxc_flush_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `mem_rd`, `mem_wr` are 0 and `pend_mask_o` is 0x00; no strobe is active while `busy` is 0.
- R2: The byte written for plane n has, at bit x, bit n of pixel x, where pixel x occupies `row_data[8x+7:8x]`.
- R3: Plane n is written at `base_addr + ((n>>1)*16 + (n&1))`, i.e. offsets 0,1,16,17,32,33,48,49. Planes are written in ascending order, and the address and data are held steady through an access.
- R4: `bpp_sel` 0 selects 2 planes, 1 selects 4 planes, and 2 or 3 select 8 planes; exactly that many planes are written.
- R5: With a mask other than 0xFF and 0x00, each plane is read before it is written and the stored byte becomes (new AND mask) OR (old AND NOT mask). With mask 0xFF, no read occurs.
- R6: Each read or write strobe stays high for exactly 5 cycles when `fast_sel`=1 and 6 cycles when 0. `done` rises B*(1+A*W) cycles after the edge that samples `start`, where B is the number of planes, W is the access cost, and A is 2 for a partial mask or 1 for a full mask.
- R7: `done` is a one-cycle pulse. In that cycle `pend_mask_o` reads 0x00, and in the next cycle `busy` is 0.
- R8: With mask 0x00 no memory access occurs, and `done` rises one cycle after the edge that samples `start`.
- R9: `start` is ignored while `busy` is 1; the inputs presented then have no effect on the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a writeback (sampled only when idle) |
| row_data | input | 64 | Eight pixels, pixel x at bits 8x+7:8x |
| pend_mask | input | 8 | Pending pixel mask, bit x for pixel x |
| bpp_sel | input | 2 | Bits-per-pixel code (0:2, 1:4, 2/3:8) |
| base_addr | input | AW | Tile base byte address |
| fast_sel | input | 1 | Access cost select (1: 5 cycles, 0: 6 cycles) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, sampled in the last read cycle |
| busy | output | 1 | Engine not idle |
| done | output | 1 | Completion pulse |
| pend_mask_o | output | 8 | Latched pending mask, cleared at completion |

## Verification
Completion is due a computed number of edges after the edge that samples `start`: B*(1+A*W) for a nonzero mask and exactly one for an empty mask. The bench counts edges from that sampling edge and compares the count at the first falling edge on which `done` is seen. Memory effects are applied by the bench model on falling edges, so every read sampled at a rising edge sees settled data. Strobe lengths, write order and the final memory image are checked after `done`, and `busy` is checked one cycle later. The bench sweeps every bits-per-pixel code, both speeds, five masks and four base addresses.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
    localparam int NPIX = 8;
    localparam int PIXW = 8;
    localparam int PLW  = $clog2(PIXW);
    localparam int PCW  = PLW + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } pxc_state_e;

    function automatic logic [PCW-1:0] plane_count(input logic [1:0] sel);
        logic [PCW-1:0] n;
        unique case (sel)
            2'd0:    n = PCW'(2);
            2'd1:    n = PCW'(4);
            default: n = PCW'(8);
        endcase
        return n;
    endfunction
endpackage

// File: rtl/pxc_plane_pack.sv
module pxc_plane_pack
    import pxc_pkg::*;
(
    input  logic [NPIX*PIXW-1:0] row,
    input  logic [PLW-1:0]       plane,
    output logic [NPIX-1:0]      plane_byte
);
    generate
        for (genvar x = 0; x < NPIX; x++) begin : g_pix
            logic [PIXW-1:0] pix;
            assign pix           = row[x*PIXW +: PIXW];
            assign plane_byte[x] = pix[plane];
        end
    endgenerate
endmodule

// File: rtl/pxc_plane_offset.sv
module pxc_plane_offset
    import pxc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]  base,
    input  logic [PLW-1:0] plane,
    output logic [AW-1:0]  addr
);
    localparam int OFW = 6;
    logic [OFW-1:0] offset;

    // planes pair up inside a 16-byte stride: pair index selects the stride, low bit the byte
    assign offset = {plane[PLW-1:1], 3'b000, plane[0]};
    assign addr   = base + {{(AW-OFW){1'b0}}, offset};
endmodule

// File: rtl/pxc_access_timer.sv
module pxc_access_timer #(
    parameter int FAST_COST = 5,
    parameter int SLOW_COST = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic fast,
    output logic expired
);
    localparam int MAXC = (FAST_COST > SLOW_COST) ? FAST_COST : SLOW_COST;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= fast ? CW'(FAST_COST - 1) : CW'(SLOW_COST - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pxc_flush_engine.sv
module pxc_flush_engine
    import pxc_pkg::*;
#(
    parameter int AW        = 16,
    parameter int FAST_COST = 5,
    parameter int SLOW_COST = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NPIX*PIXW-1:0] row_data,
    input  logic [NPIX-1:0]      pend_mask,
    input  logic [1:0]           bpp_sel,
    input  logic [AW-1:0]        base_addr,
    input  logic                 fast_sel,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [AW-1:0]        mem_addr,
    output logic [7:0]           mem_wdata,
    input  logic [7:0]           mem_rdata,
    output logic                 busy,
    output logic                 done,
    output logic [NPIX-1:0]      pend_mask_o
);
    localparam logic [NPIX-1:0] MASK_FULL = '1;

    pxc_state_e state, state_nx;

    logic [NPIX*PIXW-1:0] row_q;
    logic [NPIX-1:0]      mask_q;
    logic [PCW-1:0]       planes_q;
    logic [AW-1:0]        base_q;
    logic                 fast_q;
    logic [PLW-1:0]       plane_q;
    logic [7:0]           old_q;

    logic                 t_load;
    logic                 t_expired;
    logic                 last_plane;
    logic [NPIX-1:0]      new_byte;
    logic [AW-1:0]        plane_addr;

    pxc_plane_pack u_pack (
        .row        (row_q),
        .plane      (plane_q),
        .plane_byte (new_byte)
    );

    pxc_plane_offset #(.AW(AW)) u_offset (
        .base  (base_q),
        .plane (plane_q),
        .addr  (plane_addr)
    );

    pxc_access_timer #(.FAST_COST(FAST_COST), .SLOW_COST(SLOW_COST)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .fast    (fast_q),
        .expired (t_expired)
    );

    assign last_plane = ({1'b0, plane_q} == (planes_q - PCW'(1)));
    assign t_load     = ((state == ST_PREP) && (mask_q != '0)) ||
                        ((state == ST_READ) && t_expired);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_PREP;
            ST_PREP: begin
                if (mask_q == '0)             state_nx = ST_DONE;
                else if (mask_q == MASK_FULL) state_nx = ST_WRITE;
                else                          state_nx = ST_READ;
            end
            ST_READ:  if (t_expired) state_nx = ST_WRITE;
            ST_WRITE: if (t_expired) state_nx = last_plane ? ST_DONE : ST_PREP;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            mask_q   <= '0;
            planes_q <= '0;
            base_q   <= '0;
            fast_q   <= 1'b0;
            plane_q  <= '0;
            old_q    <= '0;
        end else begin
            if ((state == ST_IDLE) && start) begin
                row_q    <= row_data;
                mask_q   <= pend_mask;
                planes_q <= plane_count(bpp_sel);
                base_q   <= base_addr;
                fast_q   <= fast_sel;
                plane_q  <= '0;
            end
            if ((state == ST_READ) && t_expired) begin
                old_q <= mem_rdata;
            end
            if ((state == ST_WRITE) && t_expired) begin
                if (last_plane) mask_q  <= '0;
                else            plane_q <= plane_q + PLW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        mem_rd      = (state == ST_READ);
        mem_wr      = (state == ST_WRITE);
        mem_addr    = plane_addr;
        mem_wdata   = (new_byte & mask_q) | (old_q & ~mask_q);
        busy        = (state != ST_IDLE);
        done        = (state == ST_DONE);
        pend_mask_o = mask_q;
    end
endmodule

// File: rtl/pxc_flush_checker.sv
module pxc_flush_checker #(
    parameter int AW        = 16,
    parameter int FAST_COST = 5,
    parameter int SLOW_COST = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata,
    input logic [7:0]    pend_mask_o
);
    logic [7:0] wr_run;
    logic [7:0] rd_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_run <= '0;
            rd_run <= '0;
        end else begin
            wr_run <= mem_wr ? wr_run + 8'd1 : 8'd0;
            rd_run <= mem_rd ? rd_run + 8'd1 : 8'd0;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    assert_access_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_read_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |-> mem_wr);

    assert_wr_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr) |-> (wr_run == 8'(FAST_COST) || wr_run == 8'(SLOW_COST)));

    assert_rd_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |-> (rd_run == 8'(FAST_COST) || rd_run == 8'(SLOW_COST)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pend_mask_o == 8'h00));
endmodule

bind pxc_flush_engine pxc_flush_checker #(
    .AW(AW), .FAST_COST(FAST_COST), .SLOW_COST(SLOW_COST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .pend_mask_o (pend_mask_o)
);

// File: tb/tb_pxc_flush_engine.sv
`timescale 1ns/1ps
module tb_pxc_flush_engine;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [63:0]   row_data = '0;
    logic [7:0]    pend_mask = '0;
    logic [1:0]    bpp_sel = '0;
    logic [AW-1:0] base_addr = '0;
    logic          fast_sel = 1'b0;
    logic          mem_rd, mem_wr, busy, done;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, mem_rdata, pend_mask_o;

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];

    int n_checks = 0;
    int n_fail   = 0;

    // monitor state
    int            wr_cycles, rd_cycles, plane_idx, order_err;
    logic          prev_wr = 1'b0;
    logic [AW-1:0] cur_base;

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    pxc_flush_engine #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .row_data(row_data),
        .pend_mask(pend_mask), .bpp_sel(bpp_sel), .base_addr(base_addr),
        .fast_sel(fast_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pend_mask_o(pend_mask_o)
    );

    function automatic int plane_off(input int n);
        return (n / 2) * 16 + (n % 2);
    endfunction

    function automatic logic [7:0] pack(input logic [63:0] row, input int n);
        logic [7:0] b;
        for (int x = 0; x < 8; x++) b[x] = row[8*x + n];
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[7:0]] = mem_wdata;
            wr_cycles++;
            if (!prev_wr) begin
                if (mem_addr != cur_base + AW'(plane_off(plane_idx))) order_err++;
                plane_idx++;
            end
        end
        if (mem_rd) rd_cycles++;
        prev_wr = mem_wr;
    end

    task automatic run_case(input int bsel, input int fast, input logic [7:0] mask,
                            input logic [AW-1:0] base, input int seed, input bit intrude);
        int nb, w, acc, lat, cnt, bad;
        logic [63:0] row;
        logic [7:0] pk;
        int a;
        nb  = (bsel == 0) ? 2 : (bsel == 1) ? 4 : 8;
        w   = fast ? 5 : 6;
        acc = (mask == 8'hFF) ? 1 : 2;
        lat = (mask == 8'h00) ? 1 : nb * (1 + acc * w);
        row = {32'(seed * 32'h9E3779B1), 32'(seed * 32'h85EBCA6B) ^ 32'h3C5A_96E1};
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i * 29 + seed + 7);
            exp_mem[i] = mem[i];
        end
        if (mask != 8'h00) begin
            for (int n = 0; n < nb; n++) begin
                a  = int'(base[7:0]) + plane_off(n);
                pk = pack(row, n);
                exp_mem[a] = (pk & mask) | (exp_mem[a] & ~mask);
            end
        end
        wr_cycles = 0; rd_cycles = 0; plane_idx = 0; order_err = 0; cur_base = base;

        @(negedge clk);
        row_data = row; pend_mask = mask; bpp_sel = 2'(bsel);
        base_addr = base; fast_sel = fast[0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (cnt < 1000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (done) break;
            if (intrude && cnt == 3) begin
                // R9: a start during busy with other settings
                start = 1'b1; pend_mask = 8'hFF; bpp_sel = 2'd2;
                base_addr = 16'h00C4; row_data = ~row; fast_sel = ~fast_sel;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(cnt == lat, (mask == 0) ? "R8" : "R6", "done latency", cnt, lat);
        check(pend_mask_o == 8'h00, "R7", "mask cleared at done", pend_mask_o, 0);
        @(negedge clk);
        check(!done && !busy, "R7", "done single cycle then idle", {done, busy}, 0);
        check(wr_cycles == ((mask == 0) ? 0 : nb * w), "R4 R6", "write strobe cycles",
              wr_cycles, (mask == 0) ? 0 : nb * w);
        check(rd_cycles == ((mask == 0 || mask == 8'hFF) ? 0 : nb * w), "R5", "read strobe cycles",
              rd_cycles, (mask == 0 || mask == 8'hFF) ? 0 : nb * w);
        check(order_err == 0 && plane_idx == ((mask == 0) ? 0 : nb), "R3", "plane order and count",
              plane_idx, (mask == 0) ? 0 : nb);
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
        check(bad == 0, intrude ? "R9" : "R2 R5", "memory image mismatched bytes", bad, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] masks [5];
        logic [AW-1:0] bases [4];
        int seed;
        masks[0] = 8'hFF; masks[1] = 8'h00; masks[2] = 8'h5A; masks[3] = 8'h01; masks[4] = 8'h80;
        bases[0] = 16'h0000; bases[1] = 16'h0023; bases[2] = 16'h0080; bases[3] = 16'h00A7;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !mem_rd && !mem_wr && pend_mask_o == 0, "R1", "reset outputs",
              {busy, done, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && pend_mask_o == 0, "R1", "idle after reset", {busy, done}, 0);

        seed = 1;
        for (int b = 0; b < 4; b++) begin
            for (int f = 0; f < 2; f++) begin
                for (int m = 0; m < 5; m++) begin
                    run_case(b, f, masks[m], bases[(b + f + m) % 4], seed,
                             (masks[m] != 0) && (seed % 3 == 0));
                    seed++;
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule